// File: doc/BRIEF.md
# Cache Maintenance Operation Controller

This block carries out address-based maintenance requests against a small direct-mapped local cache. Each entry holds a valid bit, a dirty bit, a tag and one data word. A request has a line address and an operation code. The block looks the line up and, if the operation calls for it, writes dirty data back through a memory write port. Where the operation requires it, the block tells a fixed set of peer caches to drop the line and waits for each of them to acknowledge. It then asks the memory side to confirm that the data is visible to all agents, and only after that confirmation does it pulse completion.

Only one request is in flight at a time. The request port reports not-ready from the cycle after acceptance up to and including the completion pulse. A separate update port stands for the owning cache's own store path. It installs a line together with its data and dirty state, and it acts only while the controller is idle.

Top module: `cmo_ctrl`

## Requirements
- R1: `req_op` encodes the operation as follows: 0 is clean-and-invalidate, 1 is clean-only, 2 is invalidate-only and 3 is a no-op. A no-op completes one cycle after acceptance, writes nothing, broadcasts nothing, requests no sync and leaves the local state unchanged.
- R2: A writeback happens only when a clean-and-invalidate or clean-only request hits a dirty line. It presents the line address, with the offset bits zeroed, and the stored data on the write port. Valid, address and data stay steady until `mem_wr_ack` is sampled.
- R3: After a clean-only request, the line is still valid (a later request reports `done_hit`=1) and no longer dirty (a second clean-only writes nothing).
- R4: An invalidate-only request on a dirty line writes nothing to memory and drops the line, so a later request to it misses.
- R5: Clean-and-invalidate and invalidate-only raise `inv_valid` with the line address. Clean-only and no-op never raise it.
- R6: `inv_valid` rises only after the writeback has been acknowledged, and it is never high together with `mem_wr_valid`.
- R7: The broadcast ends on the clock edge where every bit of `inv_ack` has been seen at least once since `inv_valid` rose. The acks may arrive in any order. Repeated acks, and acks seen outside the broadcast, have no effect.
- R8: Operations 0 to 2 raise `sync_valid` after the writeback and broadcast steps. `done` pulses in the cycle after `sync_ack` is sampled.
- R9: `req_ready` is low and `busy` is high from the edge that accepts a request through the `done` cycle. `done` lasts one cycle, and `req_ready` returns in the following cycle.
- R10: A request hits only when the indexed entry (index = address bits just above the offset) is valid and its tag matches. `done_hit` reports the hit together with `done`.
- R11: The update port writes an entry while the controller is idle and is ignored while it is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Maintenance request present |
| req_ready | output | 1 | Controller can accept a request |
| req_op | input | 2 | Operation code (R1) |
| req_addr | input | ADDR_W | Request byte address |
| upd_valid | input | 1 | Install a line from the store path |
| upd_addr | input | ADDR_W | Address of the installed line |
| upd_data | input | DATA_W | Data of the installed line |
| upd_dirty | input | 1 | Dirty state of the installed line |
| mem_wr_valid | output | 1 | Writeback request |
| mem_wr_addr | output | ADDR_W | Writeback line address |
| mem_wr_data | output | DATA_W | Writeback data |
| mem_wr_ack | input | 1 | Writeback accepted |
| inv_valid | output | 1 | Invalidation broadcast to peers |
| inv_addr | output | ADDR_W | Line address to invalidate |
| inv_ack | input | NUM_PEERS | Per-peer invalidation acknowledgement |
| sync_valid | output | 1 | Request for a global visibility confirmation |
| sync_ack | input | 1 | Memory confirms visibility |
| done | output | 1 | One-cycle completion pulse |
| done_hit | output | 1 | Request found the line (valid with done) |
| busy | output | 1 | Operation in flight |

## Verification
The hardest case to reach is a broadcast that must not end early. To get there, the peer acks are spread over several cycles with one peer repeated. All peers are also held acknowledged during the preceding writeback, so that an implementation which collects acks outside the broadcast would finish in its first cycle. Dropped and cleaned lines are observed only through later requests, using their writeback activity and `done_hit`. The ignored update is exposed by a later clean that must still write nothing.

// File: rtl/cmo_pkg.sv
package cmo_pkg;

    typedef enum logic [1:0] {
        OP_CLEAN_INV = 2'd0,
        OP_CLEAN     = 2'd1,
        OP_INVAL     = 2'd2,
        OP_NOP       = 2'd3
    } cmo_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WB,
        ST_INV,
        ST_SYNC,
        ST_DONE
    } cmo_state_e;

    typedef struct packed {
        logic do_wb;
        logic do_inv;
        logic do_sync;
    } cmo_plan_t;

    function automatic cmo_plan_t make_plan(cmo_op_e op, logic hit, logic dirty);
        cmo_plan_t p;
        p.do_wb   = (op == OP_CLEAN_INV || op == OP_CLEAN) && hit && dirty;
        p.do_inv  = (op == OP_CLEAN_INV || op == OP_INVAL);
        p.do_sync = (op != OP_NOP);
        return p;
    endfunction

endpackage

// File: rtl/cmo_line_array.sv
module cmo_line_array #(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic              wr_dirty,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0]  valid_vec;
    logic [LINES-1:0]  dirty_vec;
    logic [TAG_W-1:0]  tag_arr  [LINES];
    logic [DATA_W-1:0] data_arr [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic              v_r;
        logic              d_r;
        logic [TAG_W-1:0]  t_r;
        logic [DATA_W-1:0] x_r;
        wire               sel = wr_en && (wr_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                v_r <= 1'b0;
                d_r <= 1'b0;
            end else if (sel) begin
                v_r <= wr_valid;
                d_r <= wr_dirty;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                t_r <= wr_tag;
                x_r <= wr_data;
            end
        end

        assign valid_vec[i] = v_r;
        assign dirty_vec[i] = d_r;
        assign tag_arr[i]   = t_r;
        assign data_arr[i]  = x_r;
    end

    assign rd_valid = valid_vec[rd_idx];
    assign rd_dirty = dirty_vec[rd_idx];
    assign rd_tag   = tag_arr[rd_idx];
    assign rd_data  = data_arr[rd_idx];

endmodule

// File: rtl/cmo_ack_collect.sv
module cmo_ack_collect #(
    parameter int NUM_PEERS = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic [NUM_PEERS-1:0] ack,
    output logic                 all_seen
);
    logic [NUM_PEERS-1:0] seen_q;
    logic [NUM_PEERS-1:0] seen_next;

    assign seen_next = seen_q | (enable ? ack : '0);
    assign all_seen  = enable && (&seen_next);

    always_ff @(posedge clk) begin
        if (rst || !enable) seen_q <= '0;
        else                seen_q <= seen_next;
    end

endmodule

// File: rtl/cmo_sequencer.sv
module cmo_sequencer
    import cmo_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  cmo_plan_t  plan_in,
    input  logic       wr_ack,
    input  logic       acks_done,
    input  logic       sync_ack,
    output cmo_state_e state
);
    cmo_plan_t  plan_q;
    cmo_state_e state_next;

    always_comb begin
        state_next = state;
        unique case (state)
            ST_IDLE: if (start) begin
                if (plan_in.do_wb)        state_next = ST_WB;
                else if (plan_in.do_inv)  state_next = ST_INV;
                else if (plan_in.do_sync) state_next = ST_SYNC;
                else                      state_next = ST_DONE;
            end
            ST_WB:   if (wr_ack)    state_next = plan_q.do_inv ? ST_INV : ST_SYNC;
            ST_INV:  if (acks_done) state_next = ST_SYNC;
            ST_SYNC: if (sync_ack)  state_next = ST_DONE;
            ST_DONE:                state_next = ST_IDLE;
            default:                state_next = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            plan_q <= '0;
        end else begin
            state <= state_next;
            if (state == ST_IDLE && start) plan_q <= plan_in;
        end
    end

endmodule

// File: rtl/cmo_ctrl.sv
module cmo_ctrl
    import cmo_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int OFF_W     = 4,
    parameter int IDX_W     = 2,
    parameter int DATA_W    = 32,
    parameter int NUM_PEERS = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [1:0]           req_op,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 upd_valid,
    input  logic [ADDR_W-1:0]    upd_addr,
    input  logic [DATA_W-1:0]    upd_data,
    input  logic                 upd_dirty,
    output logic                 mem_wr_valid,
    output logic [ADDR_W-1:0]    mem_wr_addr,
    output logic [DATA_W-1:0]    mem_wr_data,
    input  logic                 mem_wr_ack,
    output logic                 inv_valid,
    output logic [ADDR_W-1:0]    inv_addr,
    input  logic [NUM_PEERS-1:0] inv_ack,
    output logic                 sync_valid,
    input  logic                 sync_ack,
    output logic                 done,
    output logic                 done_hit,
    output logic                 busy
);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
    localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W)'((1 << OFF_W) - 1));

    cmo_state_e state;

    logic [ADDR_W-1:0] req_line, upd_line;
    assign req_line = req_addr & LINE_MASK;
    assign upd_line = upd_addr & LINE_MASK;

    logic              rd_valid, rd_dirty;
    logic [TAG_W-1:0]  rd_tag;
    logic [DATA_W-1:0] rd_data;
    logic              hit_now;
    logic              req_fire;
    cmo_plan_t         plan_now;

    assign req_ready = (state == ST_IDLE);
    assign req_fire  = req_valid && req_ready;
    assign hit_now   = rd_valid && (rd_tag == req_line[ADDR_W-1 -: TAG_W]);
    assign plan_now  = make_plan(cmo_op_e'(req_op), hit_now, rd_dirty);

    cmo_op_e           op_q;
    logic [ADDR_W-1:0] line_q;
    logic [DATA_W-1:0] data_q;
    logic              hit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_NOP;
            line_q <= '0;
            data_q <= '0;
            hit_q  <= 1'b0;
        end else if (req_fire) begin
            op_q   <= cmo_op_e'(req_op);
            line_q <= req_line;
            data_q <= rd_data;
            hit_q  <= hit_now;
        end
    end

    // local state update: completion of a hitting request, or an idle install
    logic              wr_en, wr_valid, wr_dirty;
    logic [IDX_W-1:0]  wr_idx;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_data;
    logic              cmd_upd, store_upd;

    assign cmd_upd   = (state == ST_DONE) && hit_q && (op_q != OP_NOP);
    assign store_upd = (state == ST_IDLE) && upd_valid;

    always_comb begin
        wr_en    = cmd_upd || store_upd;
        wr_idx   = line_q[OFF_W +: IDX_W];
        wr_tag   = line_q[ADDR_W-1 -: TAG_W];
        wr_data  = data_q;
        wr_valid = (op_q == OP_CLEAN);
        wr_dirty = 1'b0;
        if (store_upd) begin
            wr_idx   = upd_line[OFF_W +: IDX_W];
            wr_tag   = upd_line[ADDR_W-1 -: TAG_W];
            wr_data  = upd_data;
            wr_valid = 1'b1;
            wr_dirty = upd_dirty;
        end
    end

    cmo_line_array #(
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (req_line[OFF_W +: IDX_W]),
        .rd_valid (rd_valid),
        .rd_dirty (rd_dirty),
        .rd_tag   (rd_tag),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_valid (wr_valid),
        .wr_dirty (wr_dirty),
        .wr_tag   (wr_tag),
        .wr_data  (wr_data)
    );

    logic acks_done;

    cmo_ack_collect #(
        .NUM_PEERS (NUM_PEERS)
    ) u_acks (
        .clk      (clk),
        .rst      (rst),
        .enable   (state == ST_INV),
        .ack      (inv_ack),
        .all_seen (acks_done)
    );

    cmo_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (req_fire),
        .plan_in   (plan_now),
        .wr_ack    (mem_wr_ack),
        .acks_done (acks_done),
        .sync_ack  (sync_ack),
        .state     (state)
    );

    assign mem_wr_valid = (state == ST_WB);
    assign mem_wr_addr  = line_q;
    assign mem_wr_data  = data_q;
    assign inv_valid    = (state == ST_INV);
    assign inv_addr     = line_q;
    assign sync_valid   = (state == ST_SYNC);
    assign done         = (state == ST_DONE);
    assign done_hit     = done && hit_q;
    assign busy         = (state != ST_IDLE);

endmodule

// File: rtl/cmo_ctrl_checker.sv
module cmo_ctrl_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_wr_valid,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [DATA_W-1:0] mem_wr_data,
    input logic              mem_wr_ack,
    input logic              inv_valid,
    input logic              sync_valid,
    input logic              done,
    input logic              done_hit,
    input logic              busy
);
    p_wb_hold_r2: assert property (@(posedge clk) disable iff (rst)
        mem_wr_valid && !mem_wr_ack |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));

    p_wb_alone_r6: assert property (@(posedge clk) disable iff (rst)
        mem_wr_valid |-> !inv_valid && !sync_valid);

    p_wb_before_inv_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(inv_valid) && $past(mem_wr_valid) |-> $past(mem_wr_ack));

    p_inv_to_sync_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(inv_valid) |-> sync_valid);

    p_accept_busy_r9: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> busy && !req_ready);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && req_ready);

    p_hit_with_done_r10: assert property (@(posedge clk) disable iff (rst)
        done_hit |-> done);

endmodule

bind cmo_ctrl cmo_ctrl_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .mem_wr_ack   (mem_wr_ack),
    .inv_valid    (inv_valid),
    .sync_valid   (sync_valid),
    .done         (done),
    .done_hit     (done_hit),
    .busy         (busy)
);

// File: tb/cmo_ctrl_bench.sv
module cmo_ctrl_bench;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int NP = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic          upd_valid = 1'b0;
    logic [AW-1:0] upd_addr = '0;
    logic [DW-1:0] upd_data = '0;
    logic          upd_dirty = 1'b0;
    logic          mem_wr_valid;
    logic [AW-1:0] mem_wr_addr;
    logic [DW-1:0] mem_wr_data;
    logic          mem_wr_ack = 1'b0;
    logic          inv_valid;
    logic [AW-1:0] inv_addr;
    logic [NP-1:0] inv_ack = '0;
    logic          sync_valid;
    logic          sync_ack = 1'b0;
    logic          done, done_hit, busy;

    always #2 clk = ~clk;

    cmo_ctrl u_cmo_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
        .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_data(upd_data), .upd_dirty(upd_dirty),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_ack(mem_wr_ack),
        .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_ack(inv_ack),
        .sync_valid(sync_valid), .sync_ack(sync_ack),
        .done(done), .done_hit(done_hit), .busy(busy)
    );

    int checks = 0;
    int errors = 0;

    // reference model of the local lines
    bit          mv  [4];
    bit          md  [4];
    logic [9:0]  mt  [4];
    logic [31:0] mdat[4];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic install(input logic [15:0] a, input logic [31:0] d, input bit dirty);
        @(negedge clk);
        upd_valid = 1'b1; upd_addr = a; upd_data = d; upd_dirty = dirty;
        @(negedge clk);
        upd_valid = 1'b0;
        mv[a[5:4]] = 1'b1; md[a[5:4]] = dirty; mt[a[5:4]] = a[15:6]; mdat[a[5:4]] = d;
    endtask

    // mode 0: all peers ack at once; mode 1: stray acks during writeback,
    // then peer2, peer2 again, peer0, peer1 on separate cycles
    task automatic run_op(input logic [1:0] op, input logic [15:0] a,
                          input int mode, input bit stray_upd);
        int idx = int'(a[5:4]);
        bit hit = mv[idx] && (mt[idx] == a[15:6]);
        bit exp_wb = (op <= 2'd1) && hit && md[idx];
        bit exp_inv = (op == 2'd0) || (op == 2'd2);
        bit exp_sync = (op != 2'd3);
        logic [15:0] line = {a[15:4], 4'h0};
        int wb_cyc = 0, inv_cyc = 0, sync_cyc = 0;
        bit wb_acked = 0, got_done = 0;
        int inv_len = (mode == 1) ? 4 : 1;

        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        for (int cyc = 0; cyc < 200 && !got_done; cyc++) begin
            mem_wr_ack = 1'b0; inv_ack = '0; sync_ack = 1'b0;
            upd_valid = 1'b0;
            if (stray_upd && cyc == 0) begin
                upd_valid = 1'b1; upd_addr = a; upd_data = 32'hDEADBEEF; upd_dirty = 1'b1;
            end
            chk(!req_ready && busy, "R9", "ready low / busy high in flight",
                {req_ready, busy}, 2'b01);
            if (mem_wr_valid) begin
                wb_cyc++;
                chk(exp_wb, "R2", "unexpected writeback", 1, 0);
                chk(mem_wr_addr == line, "R2", "writeback address", mem_wr_addr, line);
                chk(mem_wr_data == mdat[idx], "R2", "writeback data", mem_wr_data, mdat[idx]);
                chk(!inv_valid && !sync_valid, "R6", "writeback overlaps later step",
                    {inv_valid, sync_valid}, 0);
                if (wb_cyc == 2) begin mem_wr_ack = 1'b1; wb_acked = 1; end
                if (mode == 1) inv_ack = '1;
            end
            if (inv_valid) begin
                inv_cyc++;
                chk(exp_inv, "R5", "unexpected broadcast", 1, 0);
                chk(inv_addr == line, "R5", "broadcast address", inv_addr, line);
                chk(!exp_wb || wb_acked, "R6", "broadcast before writeback ack", wb_acked, 1);
                if (mode == 1) begin
                    case (inv_cyc)
                        1: inv_ack = 3'b100;
                        2: inv_ack = 3'b100;
                        3: inv_ack = 3'b001;
                        4: inv_ack = 3'b010;
                        default: inv_ack = '0;
                    endcase
                end else if (inv_cyc == 1) inv_ack = '1;
            end
            if (sync_valid) begin
                sync_cyc++;
                chk(exp_sync, "R1", "sync for no-op", 1, 0);
                chk(!exp_inv || inv_cyc == inv_len, "R7", "sync before all peer acks",
                    inv_cyc, inv_len);
                chk(!exp_wb || wb_acked, "R8", "sync before writeback ack", wb_acked, 1);
                if (sync_cyc == 2) sync_ack = 1'b1;
            end
            if (done) begin
                got_done = 1;
                chk(sync_cyc == (exp_sync ? 2 : 0), "R8", "done vs sync ack timing",
                    sync_cyc, exp_sync ? 2 : 0);
                chk(done_hit == hit, "R10", "done_hit", done_hit, hit);
            end
            if (!got_done) @(negedge clk);
        end
        mem_wr_ack = 1'b0; inv_ack = '0; sync_ack = 1'b0;
        chk(got_done, "R8", "completion seen", got_done, 1);
        chk(wb_cyc == (exp_wb ? 2 : 0), "R2", "writeback cycles", wb_cyc, exp_wb ? 2 : 0);
        chk(inv_cyc == (exp_inv ? inv_len : 0), "R7", "broadcast cycles",
            inv_cyc, exp_inv ? inv_len : 0);
        @(negedge clk);
        upd_valid = 1'b0;
        chk(req_ready && !done && !busy, "R9", "ready returns after done pulse",
            {req_ready, done, busy}, 3'b100);
        if (hit && op != 2'd3) begin
            if (op == 2'd1) md[idx] = 1'b0;
            else begin mv[idx] = 1'b0; md[idx] = 1'b0; end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin mv[i] = 0; md[i] = 0; mt[i] = '0; mdat[i] = '0; end
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !busy && !done, "R9", "reset handshake", {req_ready, busy, done}, 3'b100);
        chk(!mem_wr_valid && !inv_valid && !sync_valid, "R6", "reset outputs idle",
            {mem_wr_valid, inv_valid, sync_valid}, 0);

        // R2/R3: clean-only on dirty line, then again (no writeback, still valid)
        install(16'h1230, 32'hAAAA0001, 1'b1);
        run_op(2'd1, 16'h1234, 0, 0);
        run_op(2'd1, 16'h1230, 0, 0);

        // R6/R7: clean-and-invalidate with staggered and repeated acks
        install(16'h0040, 32'hBBBB0002, 1'b1);
        run_op(2'd0, 16'h004C, 1, 0);
        run_op(2'd1, 16'h0040, 0, 0);          // now a miss

        // R4: invalidate-only on dirty line discards data
        install(16'h0010, 32'hCCCC0003, 1'b1);
        run_op(2'd2, 16'h0018, 0, 0);
        run_op(2'd1, 16'h0010, 0, 0);          // miss, no writeback

        // R10: same index, different tag misses
        install(16'h0020, 32'hDDDD0004, 1'b1);
        run_op(2'd1, 16'h0420, 0, 0);
        run_op(2'd1, 16'h0020, 0, 0);          // the real line still writes back

        // R1: no-op leaves a dirty line dirty
        install(16'h1230, 32'hEEEE0005, 1'b1);
        run_op(2'd3, 16'h1230, 0, 0);
        run_op(2'd1, 16'h1230, 0, 0);

        // R5: clean-and-invalidate on a miss broadcasts without writeback
        run_op(2'd0, 16'h7770, 1, 0);

        // R11: update while busy is ignored
        install(16'h0030, 32'h12345678, 1'b0);
        run_op(2'd1, 16'h0030, 0, 1);
        run_op(2'd1, 16'h0030, 0, 0);          // still clean: no writeback

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule